// File: doc/BRIEF.md
# Serial Flash Command Frame Transmitter

This block turns a handful of software-written registers into one short command frame on an SPI link to a serial flash device. Software writes an opcode byte, up to three trailing address or data bytes and a byte count, then sets a start bit. The block pulls chip select low and clocks the bytes out with the most significant bit first. It then releases chip select and reports completion with a sticky interrupt flag.

The opcode always goes out first. The trailing bytes follow from the highest-numbered data register down to the lowest, so a count of 2 sends the opcode and data register 3 only. The byte count includes the opcode. The start bit and the byte count both clear themselves when the frame ends. The serial clock is the system clock divided by an even, programmable ratio. While a frame runs, every register write is dropped, so the frame in flight and the next one cannot be corrupted.

The register port is a plain one-cycle write strobe with a select and a byte of data. There is no streaming data path, so no valid/ready handshake applies and there is no back-pressure. The status pins are level outputs.

Top module: `spi_cmd_sequencer`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, and busy, start bit, byte count and interrupt flag are all 0.
- R2: A frame carries, MSB first, the opcode (select 0), then data register 3 (select 3), register 2 (select 2) and register 1 (select 1), stopping after count bytes. The count (select 4, bits 2:0) includes the opcode, and exactly 8 x count serial clock rising edges occur.
- R3: The serial clock idles low (mode 0). The data line holds steady for as long as the serial clock is high, so it changes only while the clock is low.
- R4: Chip select is low for the whole frame, and the serial clock is high only while chip select is low.
- R5: The divisor register (select 6) holds a value N. Rising serial clock edges are 2 x N system clock cycles apart, and N = 0 acts as N = 1.
- R6: When a frame ends, the start bit (select 5, bit 0) and the byte count read back as 0.
- R7: The interrupt flag sets when a frame ends and stays set until irq_clr is pulsed.
- R8: With a count of 0 or greater than 4, setting the start bit sends nothing. Chip select stays high, the start bit clears within two cycles, and the interrupt flag does not set.
- R9: Busy is high during a frame. Writes to any register during a frame are ignored, so the next frame sends the old opcode, data and clock ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 opcode, 1-3 data, 4 count, 5 control, 6 divisor |
| reg_wdata | input | 8 | Register write data |
| irq_clr | input | 1 | Clears the interrupt flag |
| busy | output | 1 | Frame in progress |
| tx_go | output | 1 | Start bit readback |
| byte_count | output | 3 | Byte count readback |
| irq_flag | output | 1 | Sticky frame-end flag |
| spi_ss_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |

## Verification
Several properties are checked on every cycle. The clock is only high inside chip select, and the data line is stable while the clock is high. The clock falls whenever its enable drops. A frame end clears the start bit and the count and sets the flag. A rejected count leaves the interrupt flag alone, and register writes during busy leave the registers unchanged. Other behaviour can only be shown by the bench's scenarios, which sweep every legal count across several divisors and byte patterns: the bit order on the wire, the exact number of clock edges, the spacing between edges, the flag holding until it is cleared, and a frame that follows ignored writes still using the old values.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TAIL  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/spi_seq_regs.sv
module spi_seq_regs #(
  parameter int MAX_BYTES = 4,
  parameter int BYTE_W    = 8,
  parameter int DIV_W     = 8,
  parameter int CNT_W     = 3,
  parameter int SEL_W     = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [SEL_W-1:0]                sel,
  input  logic [BYTE_W-1:0]               wdata,
  input  logic                            irq_clr,
  input  logic                            busy,
  input  logic                            frame_done,
  input  logic                            frame_reject,
  output logic [BYTE_W-1:0]               instr_q,
  output logic [(MAX_BYTES-1)*BYTE_W-1:0] data_flat,
  output logic [CNT_W-1:0]                count_q,
  output logic [DIV_W-1:0]                half_q,
  output logic                            go_q,
  output logic                            irq_q
);
  localparam int SEL_INSTR = 0;
  localparam int SEL_COUNT = MAX_BYTES;
  localparam int SEL_CTRL  = MAX_BYTES + 1;
  localparam int SEL_DIV   = MAX_BYTES + 2;

  logic wr_ok;
  assign wr_ok = we && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) instr_q <= '0;
    else if (wr_ok && sel == SEL_W'(SEL_INSTR)) instr_q <= wdata;
  end

  genvar gi;
  generate
    for (gi = 1; gi < MAX_BYTES; gi++) begin : g_data
      logic [BYTE_W-1:0] dq;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dq <= '0;
        else if (wr_ok && sel == SEL_W'(gi)) dq <= wdata;
      end
      assign data_flat[(gi-1)*BYTE_W +: BYTE_W] = dq;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else if (frame_done) count_q <= '0;
    else if (wr_ok && sel == SEL_W'(SEL_COUNT)) count_q <= wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= DIV_W'(1);
    else if (wr_ok && sel == SEL_W'(SEL_DIV)) half_q <= wdata[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) go_q <= 1'b0;
    else if (frame_done || frame_reject) go_q <= 1'b0;
    else if (wr_ok && sel == SEL_W'(SEL_CTRL)) go_q <= wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else if (frame_done) irq_q <= 1'b1;
    else if (irq_clr) irq_q <= 1'b0;
  end

  // R6: end of frame clears start bit and count
  p_auto_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (!go_q && count_q == '0));
  // R7: end of frame sets the flag
  p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> irq_q);
  // R8: a rejected start never touches the flag
  p_reject_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_reject && !irq_clr) |=> ($stable(irq_q) && !go_q));
  // R9: writes while busy are dropped
  p_locked_instr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && we && sel == SEL_W'(SEL_INSTR)) |=> $stable(instr_q));
  p_locked_div_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && we && sel == SEL_W'(SEL_DIV)) |=> $stable(half_q));
endmodule

// File: rtl/spi_seq_clkdiv.sv
module spi_seq_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] half,
  output logic             sck,
  output logic             rise_p,
  output logic             fall_p
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;
  logic             tick;

  assign lim  = (half == '0) ? '0 : half - DIV_W'(1);
  assign tick = en && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck   <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      sck   <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      sck   <= ~sck;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign rise_p = tick && !sck;
  assign fall_p = tick && sck;

  // R3: clock returns to idle low whenever disabled
  p_sck_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !sck);
  // R5: a rise pulse produces a high clock next cycle
  p_rise_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_p |=> sck);
endmodule

// File: rtl/spi_seq_shift.sv
module spi_seq_shift #(
  parameter int FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_word,
  input  logic               shift,
  output logic               mosi
);
  logic [FRAME_W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else if (load) sr_q <= load_word;
    else if (shift) sr_q <= {sr_q[FRAME_W-2:0], 1'b0};
  end

  assign mosi = sr_q[FRAME_W-1];

  // R2: loaded word presents its top bit first
  p_msb_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (mosi == $past(load_word[FRAME_W-1])));
endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
#(
  parameter int MAX_BYTES = 4,
  parameter int BYTE_W    = 8,
  parameter int CNT_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CNT_W-1:0] count,
  input  logic             fall_p,
  output logic             start,
  output logic             frame_done,
  output logic             frame_reject,
  output logic             busy,
  output logic             ss_n,
  output logic             clk_en
);
  localparam int BITS_W = $clog2(MAX_BYTES * BYTE_W + 1);

  seq_state_e        state_q;
  logic [BITS_W-1:0] bits_q;
  logic              cnt_ok;

  assign cnt_ok       = (count != '0) && (count <= CNT_W'(MAX_BYTES));
  assign start        = (state_q == ST_IDLE) && go && cnt_ok;
  assign frame_reject = (state_q == ST_IDLE) && go && !cnt_ok;
  assign frame_done   = (state_q == ST_TAIL);
  assign busy         = (state_q != ST_IDLE);
  assign ss_n         = (state_q == ST_IDLE);
  assign clk_en       = (state_q == ST_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bits_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_SHIFT;
            bits_q  <= BITS_W'(count) * BITS_W'(BYTE_W);
          end
        end
        ST_SHIFT: begin
          if (fall_p) begin
            bits_q <= bits_q - BITS_W'(1);
            if (bits_q == BITS_W'(1)) state_q <= ST_TAIL;
          end
        end
        ST_TAIL: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4: the tail cycle releases chip select on the next edge
  p_tail_short_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> ss_n);
  // R8: a reject never leaves idle
  p_reject_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_reject |=> !busy);
  // R2: shifting always has bits outstanding
  p_bits_left_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> (bits_q != '0));
endmodule

// File: rtl/spi_cmd_sequencer.sv
module spi_cmd_sequencer #(
  parameter int MAX_BYTES = 4,
  parameter int BYTE_W    = 8,
  parameter int DIV_W     = 8,
  parameter int CNT_W     = $clog2(MAX_BYTES + 1),
  parameter int SEL_W     = $clog2(MAX_BYTES + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              irq_clr,
  output logic              busy,
  output logic              tx_go,
  output logic [CNT_W-1:0]  byte_count,
  output logic              irq_flag,
  output logic              spi_ss_n,
  output logic              spi_sck,
  output logic              spi_mosi
);
  localparam int FRAME_W = MAX_BYTES * BYTE_W;

  logic [BYTE_W-1:0]               instr_q;
  logic [(MAX_BYTES-1)*BYTE_W-1:0] data_flat;
  logic [DIV_W-1:0]                half_q;
  logic                            start, frame_done, frame_reject, clk_en;
  logic                            rise_p, fall_p;

  spi_seq_regs #(
    .MAX_BYTES(MAX_BYTES), .BYTE_W(BYTE_W), .DIV_W(DIV_W),
    .CNT_W(CNT_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .irq_clr(irq_clr), .busy(busy), .frame_done(frame_done),
    .frame_reject(frame_reject), .instr_q(instr_q), .data_flat(data_flat),
    .count_q(byte_count), .half_q(half_q), .go_q(tx_go), .irq_q(irq_flag)
  );

  spi_seq_ctrl #(
    .MAX_BYTES(MAX_BYTES), .BYTE_W(BYTE_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .go(tx_go), .count(byte_count), .fall_p(fall_p),
    .start(start), .frame_done(frame_done), .frame_reject(frame_reject),
    .busy(busy), .ss_n(spi_ss_n), .clk_en(clk_en)
  );

  spi_seq_clkdiv #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(clk_en), .half(half_q),
    .sck(spi_sck), .rise_p(rise_p), .fall_p(fall_p)
  );

  spi_seq_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(start), .load_word({instr_q, data_flat}),
    .shift(fall_p), .mosi(spi_mosi)
  );

  // R4: clock high only inside chip select
  p_sck_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> !spi_ss_n);
  // R3: data steady while the clock is high
  p_mosi_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));
endmodule

// File: tb/tb_spi_cmd_sequencer.sv
module tb_spi_cmd_sequencer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic       irq_clr = 1'b0;
  logic       busy, tx_go, irq_flag, spi_ss_n, spi_sck, spi_mosi;
  logic [2:0] byte_count;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  spi_cmd_sequencer dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .irq_clr(irq_clr), .busy(busy), .tx_go(tx_go),
    .byte_count(byte_count), .irq_flag(irq_flag), .spi_ss_n(spi_ss_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] sel, input logic [7:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // Runs one frame and checks wire contents; poke drives writes mid-frame (R9)
  task automatic run_frame(input logic [7:0] ins, input logic [7:0] d1,
                           input logic [7:0] d2, input logic [7:0] d3,
                           input int cnt, input int h, input bit load,
                           input bit poke);
    logic [31:0] word, cap;
    int rises, gapbad, ssbad, mosibad, last_rise, eh;
    bit seen, prev_sck, prev_mosi, busy_seen;
    eh = (h == 0) ? 1 : h;
    if (load) begin
      wr(3'd6, 8'(h));
      wr(3'd0, ins); wr(3'd1, d1); wr(3'd2, d2); wr(3'd3, d3);
    end
    wr(3'd4, 8'(cnt));
    wr(3'd5, 8'h01);
    word = {ins, d3, d2, d1};
    cap = '0; rises = 0; gapbad = 0; ssbad = 0; mosibad = 0;
    last_rise = -1; seen = 0; prev_sck = 0; prev_mosi = 0; busy_seen = 0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (poke) begin
        reg_we = (k >= 4 && k < 9);
        case (k)
          4: begin reg_sel = 3'd0; reg_wdata = ~ins; end
          5: begin reg_sel = 3'd3; reg_wdata = ~d3; end
          6: begin reg_sel = 3'd6; reg_wdata = 8'd7; end
          7: begin reg_sel = 3'd1; reg_wdata = ~d1; end
          8: begin reg_sel = 3'd2; reg_wdata = ~d2; end
          default: ;
        endcase
      end
      if (busy) busy_seen = 1;
      if (spi_sck && spi_ss_n) ssbad++;
      if (spi_sck && prev_sck && (spi_mosi != prev_mosi)) mosibad++;
      if (spi_sck && !prev_sck) begin
        rises++;
        cap = {cap[30:0], spi_mosi};
        if (last_rise >= 0 && (k - last_rise) != 2 * eh) gapbad++;
        last_rise = k;
      end
      prev_sck = spi_sck; prev_mosi = spi_mosi;
      if (busy_seen && !busy) begin seen = 1; break; end
    end
    reg_we = 1'b0;
    chk("R9 busy seen during frame", 64'(busy_seen), 64'd1);
    chk("R2 bits on the wire", 64'(cap & ((cnt == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*cnt)) - 1))),
        64'(word >> (32 - 8*cnt)));
    chk("R2 rising edge count", 64'(rises), 64'(8*cnt));
    chk("R5 edge spacing errors", 64'(gapbad), 64'd0);
    chk("R4 clock outside select", 64'(ssbad), 64'd0);
    chk("R3 data moved while clock high", 64'(mosibad), 64'd0);
    chk("R4 select released", 64'(spi_ss_n), 64'd1);
    chk("R6 start bit cleared", 64'(tx_go), 64'd0);
    chk("R6 count cleared", 64'(byte_count), 64'd0);
    chk("R7 flag set", 64'(irq_flag), 64'd1);
    repeat (4) @(negedge clk);
    chk("R7 flag holds", 64'(irq_flag), 64'd1);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R7 flag cleared", 64'(irq_flag), 64'd0);
    if (!seen) chk("R2 frame finished", 64'd0, 64'd1);
  endtask

  task automatic bad_count(input int cnt);
    int lowcyc;
    wr(3'd4, 8'(cnt));
    wr(3'd5, 8'h01);
    lowcyc = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (!spi_ss_n || busy) lowcyc++;
    end
    chk("R8 no frame for bad count", 64'(lowcyc), 64'd0);
    chk("R8 start bit cleared", 64'(tx_go), 64'd0);
    chk("R8 flag stays clear", 64'(irq_flag), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 select idle", 64'(spi_ss_n), 64'd1);
    chk("R1 clock idle", 64'(spi_sck), 64'd0);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 flag", 64'(irq_flag), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 start bit", 64'(tx_go), 64'd0);
    chk("R1 count", 64'(byte_count), 64'd0);

    run_frame(8'h52, 8'h06, 8'h4A, 8'h76, 4, 1, 1, 0);

    for (int c = 1; c <= 4; c++)
      for (int h = 0; h <= 3; h++)
        for (int p = 0; p < 3; p++)
          run_frame(8'(8'h9C ^ (p*37 + c)), 8'(p*91 + 8'h11), 8'(h*53 + 8'hC3),
                    8'(c*29 ^ 8'hA5), c, h, 1, 0);

    for (int c = 0; c <= 7; c++)
      if (c == 0 || c > 4) bad_count(c);

    // R9: writes during a frame leave the next frame unchanged
    run_frame(8'h3B, 8'h81, 8'h5E, 8'hE2, 4, 2, 1, 1);
    run_frame(8'h3B, 8'h81, 8'h5E, 8'hE2, 4, 2, 0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule